// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a word clock that selects left or right, and one data line. It runs directly in the bit-clock domain. Every rising bit-clock edge samples the word clock and the data line. Whenever the word clock changes level, the half-frame that just ended is handed out as a parallel 32-bit word. The word comes with a one-cycle valid strobe and a flag that says which channel it belongs to.

Three framings are supported: I2S, left-justified and right-justified. In the two MSB-first framings every word is taken as a full 32-bit value. In right-justified framing only the final N bits before the word-clock change are kept, with N being 16, 20, 24 or 32. A half-frame with too few bit clocks gives a word that is left-aligned, with zeros in the bit positions that were never sent. No dither and no rounding are applied; the received bits go out unchanged.

The configuration inputs are static. They are changed only while the block is held in reset.

Top module: `ser_audio_rx`

## Requirements
- R1: While `rst` is high and after it, `word_valid` and `word_data` are 0. The half-frame in progress when reset ends produces no word, so the first word-clock change seen after reset emits nothing.
- R2: `cfg_fmt` encoding: 00 = I2S, 01 = left-justified, 10 = right-justified. 11 behaves exactly like left-justified.
- R3: Left-justified: the MSB is the bit sampled on the first rising edge at which the new word-clock level is seen. Further bits follow MSB first. Word clock high marks the left channel.
- R4: I2S: the MSB is sampled on the second rising edge after the word-clock change. The bit sampled on the edge that first shows the new level is the LSB of the preceding word. Word clock low marks the left channel.
- R5: Right-justified: `cfg_depth` 00/01/10/11 selects N = 16/20/24/32. The word is made of the last N bits sampled before the word-clock change. It is placed in `word_data[31:32-N]` with zeros below. Earlier bits of a longer half-frame are discarded.
- R6: A half-frame that delivers fewer bits than the word needs (32, or N in right-justified) gives those bits left-aligned from bit 31 down, with all lower bits 0.
- R7: In the MSB-first framings, bits after the 32nd of a half-frame are ignored.
- R8: `word_valid` is high for exactly one cycle, once per half-frame. That cycle follows the edge that samples the word-clock change. `word_left` names the channel of the finished half-frame, and `word_data` holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lr_sel | input | 1 | Word clock (channel select) |
| ser_data | input | 1 | Serial data line |
| cfg_fmt | input | 2 | Framing select (see R2) |
| cfg_depth | input | 2 | Right-justified word depth code (see R5) |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_left | output | 1 | High when the finished word is a left-channel sample |
| word_data | output | 32 | Received word, MSB-aligned |

## Verification
A word is due in the cycle right after the rising edge that first samples the new word-clock level. That edge passes through a single output register, so the result is available one edge after the change. The bench drives inputs on falling edges. It reads the strobe, channel flag and data at the falling edge that follows the transition edge, and there is no further delay to wait for. Every other cycle of a half-frame is sampled at its falling edge to confirm the strobe stays low, and the cycle after a strobe is checked for held data.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W) + 1;
    localparam int IDX_W  = CNT_W - 1;

    typedef enum logic [1:0] {
        FMT_I2S    = 2'b00,
        FMT_LEFTJ  = 2'b01,
        FMT_RIGHTJ = 2'b10,
        FMT_ALT    = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              left;
    } word_t;

    // Right-justified depth code to bit count
    function automatic logic [CNT_W-1:0] depth_bits(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(16);
            2'b01:   return CNT_W'(20);
            2'b10:   return CNT_W'(24);
            default: return CNT_W'(WORD_W);
        endcase
    endfunction

    // Move the low m bits of a shift register to the top, zero below
    function automatic logic [WORD_W-1:0] keep_top(input logic [WORD_W-1:0] sh,
                                                   input logic [CNT_W-1:0]  m);
        return sh << (CNT_W'(WORD_W) - m);
    endfunction

endpackage

// File: rtl/ser_rx_frame_sync.sv
module ser_rx_frame_sync (
    input  logic clk,
    input  logic rst,
    input  logic lr_sel,
    output logic lr_q,
    output logic trans,
    output logic synced
);
    logic primed;

    assign trans = primed && (lr_sel != lr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_q   <= 1'b0;
            primed <= 1'b0;
            synced <= 1'b0;
        end else begin
            lr_q   <= lr_sel;
            primed <= 1'b1;
            if (trans) synced <= 1'b1;
        end
    end

    AST_SYNC_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        trans |=> synced); // R1

endmodule

// File: rtl/ser_rx_msb_acc.sv
module ser_rx_msb_acc
    import ser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sd,
    input  logic              trans,
    input  logic              fmt_i2s,
    output logic [WORD_W-1:0] word_out
);
    logic [WORD_W-1:0] acc, acc_ins;
    logic [CNT_W-1:0]  cnt;
    logic              room;

    assign room = cnt < CNT_W'(WORD_W);

    always_comb begin
        acc_ins = acc;
        if (room) acc_ins[IDX_W'(WORD_W-1) - cnt[IDX_W-1:0]] = sd;
    end

    // I2S: the bit at the transition edge still belongs to the old word
    assign word_out = fmt_i2s ? acc_ins : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            cnt <= '0;
        end else if (trans) begin
            if (fmt_i2s) begin
                acc <= '0;
                cnt <= '0;
            end else begin
                acc <= {sd, {(WORD_W-1){1'b0}}};
                cnt <= CNT_W'(1);
            end
        end else begin
            acc <= acc_ins;
            if (room) cnt <= cnt + CNT_W'(1);
        end
    end

    AST_FULL_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!trans && !room) |=> (acc == $past(acc))); // R7

endmodule

// File: rtl/ser_rx_lsb_shift.sv
module ser_rx_lsb_shift
    import ser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sd,
    input  logic              trans,
    input  logic [1:0]        depth_code,
    output logic [WORD_W-1:0] word_out
);
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt, need, take;

    assign need     = depth_bits(depth_code);
    assign take     = (cnt < need) ? cnt : need;
    assign word_out = keep_top(sh, take);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else begin
            sh <= {sh[WORD_W-2:0], sd};
            if (trans)                        cnt <= CNT_W'(1);
            else if (cnt < CNT_W'(WORD_W))    cnt <= cnt + CNT_W'(1);
        end
    end

    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        trans |=> (cnt == CNT_W'(1))); // R5

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
    import ser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lr_sel,
    input  logic              ser_data,
    input  logic [1:0]        cfg_fmt,
    input  logic [1:0]        cfg_depth,
    output logic              word_valid,
    output logic              word_left,
    output logic [WORD_W-1:0] word_data
);
    fmt_e              fmt;
    logic              lr_q, trans, synced, emit, is_i2s, is_rj;
    logic [WORD_W-1:0] msb_word, lsb_word;
    word_t             nxt, outr;
    logic              vld;

    assign fmt    = fmt_e'(cfg_fmt);
    assign is_i2s = (fmt == FMT_I2S);
    assign is_rj  = (fmt == FMT_RIGHTJ);

    ser_rx_frame_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .lr_sel (lr_sel),
        .lr_q   (lr_q),
        .trans  (trans),
        .synced (synced)
    );

    ser_rx_msb_acc u_msb (
        .clk      (clk),
        .rst      (rst),
        .sd       (ser_data),
        .trans    (trans),
        .fmt_i2s  (is_i2s),
        .word_out (msb_word)
    );

    ser_rx_lsb_shift u_lsb (
        .clk        (clk),
        .rst        (rst),
        .sd         (ser_data),
        .trans      (trans),
        .depth_code (cfg_depth),
        .word_out   (lsb_word)
    );

    assign emit      = trans && synced;
    assign nxt.data  = is_rj ? lsb_word : msb_word;
    assign nxt.left  = is_i2s ? ~lr_q : lr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            outr <= '0;
        end else begin
            vld <= emit;
            if (emit) outr <= nxt;
        end
    end

    assign word_valid = vld;
    assign word_left  = outr.left;
    assign word_data  = outr.data;

    // Checker state: channel of the previous strobe
    logic prev_left, seen_word;
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_left <= 1'b0;
            seen_word <= 1'b0;
        end else if (word_valid) begin
            prev_left <= word_left;
            seen_word <= 1'b1;
        end
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !word_valid); // R1
    AST_STROBE_ON_WS_EDGE: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (lr_q != $past(lr_q))); // R8
    AST_CHANNEL_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (word_valid && seen_word) |-> (word_left != prev_left)); // R8
    AST_RJ16_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (word_valid && $past(cfg_fmt) == FMT_RIGHTJ && $past(cfg_depth) == 2'b00)
        |-> (word_data[15:0] == 16'h0)); // R5

endmodule

// File: tb/sim_ser_audio_rx.sv
`timescale 1ns/1ps
module sim_ser_audio_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lr_sel = 1'b0;
    logic        ser_data = 1'b0;
    logic [1:0]  cfg_fmt = 2'b01;
    logic [1:0]  cfg_depth = 2'b00;
    logic        word_valid, word_left;
    logic [31:0] word_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ser_audio_rx u0 (
        .clk        (clk),
        .rst        (rst),
        .lr_sel     (lr_sel),
        .ser_data   (ser_data),
        .cfg_fmt    (cfg_fmt),
        .cfg_depth  (cfg_depth),
        .word_valid (word_valid),
        .word_left  (word_left),
        .word_data  (word_data)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  depth;
        logic        lvl;
        logic [5:0]  len;
        logic [39:0] pat;
        logic        tb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        {2'b01, 2'b00, 1'b1, 6'd32, 40'hA5C30F9612, 1'b0},
        {2'b01, 2'b00, 1'b0, 6'd32, 40'h123456789A, 1'b1},
        {2'b00, 2'b00, 1'b0, 6'd32, 40'h5A5A5A5AFF, 1'b1},
        {2'b00, 2'b00, 1'b1, 6'd32, 40'hF0E1D2C3B4, 1'b0},
        {2'b01, 2'b00, 1'b1, 6'd24, 40'hDEADBEEF00, 1'b0},
        {2'b01, 2'b00, 1'b0, 6'd36, 40'h8765432ABC, 1'b1},
        {2'b10, 2'b00, 1'b1, 6'd32, 40'hCAFEBABE55, 1'b0},
        {2'b10, 2'b01, 1'b0, 6'd24, 40'h9ABCDEF012, 1'b1},
        {2'b10, 2'b10, 1'b1, 6'd32, 40'h13579BDF02, 1'b0},
        {2'b10, 2'b11, 1'b0, 6'd32, 40'hFEDCBA9876, 1'b0},
        {2'b10, 2'b11, 1'b1, 6'd20, 40'hABCDE12345, 1'b0},
        {2'b00, 2'b00, 1'b0, 6'd16, 40'hC3A5F0F0F0, 1'b1},
        {2'b11, 2'b00, 1'b1, 6'd32, 40'h0F1E2D3C4B, 1'b1},
        {2'b10, 2'b00, 1'b0, 6'd40, 40'hF00DFACE77, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int depth_of(input logic [1:0] d);
        return (d == 2'b00) ? 16 : (d == 2'b01) ? 20 : (d == 2'b10) ? 24 : 32;
    endfunction

    // Expected word from the framing rules
    function automatic logic [31:0] model(input vec_t v);
        logic [40:0] b = '0;
        int n = 0;
        int m;
        logic [31:0] res = '0;
        int len = int'(v.len);
        if (v.mode == 2'b00) begin
            for (int k = 1; k < len; k++) begin b[n] = v.pat[39-k]; n++; end
            b[n] = v.tb; n++;
        end else begin
            for (int k = 0; k < len; k++) begin b[n] = v.pat[39-k]; n++; end
        end
        if (v.mode == 2'b10) begin
            m = (n < depth_of(v.depth)) ? n : depth_of(v.depth);
            for (int i = 0; i < m; i++) res[31-i] = b[n-m+i];
        end else begin
            m = (n < 32) ? n : 32;
            for (int i = 0; i < m; i++) res[31-i] = b[i];
        end
        return res;
    endfunction

    function automatic string tag_of(input vec_t v);
        int len = int'(v.len);
        if (v.mode == 2'b11) return "R2";
        if (v.mode == 2'b10) return (len < depth_of(v.depth)) ? "R6" : "R5";
        if (len < 32) return "R6";
        if (len > 32) return "R7";
        return (v.mode == 2'b00) ? "R4" : "R3";
    endfunction

    task automatic do_reset(input logic [1:0] f, input logic [1:0] d, input logic lvl);
        @(negedge clk);
        rst = 1'b1; cfg_fmt = f; cfg_depth = d; lr_sel = lvl; ser_data = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", {30'b0, word_valid, word_left}, 32'h0);
        chk("R1", word_data, 32'h0);
        rst = 1'b0;
        repeat (3) begin ser_data = ~ser_data; @(negedge clk); end
    endtask

    task automatic run_entry(input vec_t v);
        int pulses = 0;
        logic [31:0] exp = model(v);
        logic exp_left = (v.mode == 2'b00) ? ~v.lvl : v.lvl;
        do_reset(v.mode, v.depth, ~v.lvl);
        for (int k = 0; k < int'(v.len); k++) begin
            lr_sel = v.lvl; ser_data = v.pat[39-k];
            @(negedge clk);
            if (k == 0) chk("R1", {31'b0, word_valid}, 32'h0);
            else if (word_valid) pulses++;
        end
        lr_sel = ~v.lvl; ser_data = v.tb;
        @(negedge clk);
        chk("R8", {31'b0, word_valid}, 32'h1);
        chk(tag_of(v), word_data, exp);
        chk((v.mode == 2'b00) ? "R4" : "R3", {31'b0, word_left}, {31'b0, exp_left});
        chk("R8", pulses, 0);
        ser_data = 1'b1;
        @(negedge clk);
        chk("R8", {31'b0, word_valid}, 32'h0);
        chk("R8", word_data, exp);
    endtask

    initial begin
        logic [1:0] p, pp;
        logic plvl;
        for (int i = 0; i < NV; i++) run_entry(TBL[i]);

        // Back-to-back two-bit half-frames, left-justified
        do_reset(2'b01, 2'b00, 1'b0);
        pp = 2'b00; plvl = 1'b0;
        for (int j = 0; j < 6; j++) begin
            p = 2'(j + 1);
            lr_sel = ~j[0]; ser_data = p[1];
            @(negedge clk);
            if (j == 0) chk("R1", {31'b0, word_valid}, 32'h0);
            else begin
                chk("R8", {31'b0, word_valid}, 32'h1);
                chk("R6", word_data, {pp, 30'b0});
                chk("R3", {31'b0, word_left}, {31'b0, plvl});
            end
            ser_data = p[0];
            @(negedge clk);
            chk("R8", {31'b0, word_valid}, 32'h0);
            pp = p; plvl = ~j[0];
        end

        // Reset in the middle of a stream clears the outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", {31'b0, word_valid}, 32'h0);
        chk("R1", word_data, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule